// File: doc/BRIEF.md
# Processor Status Word with Condition Flags

This block holds a 16-bit processor status word. The low byte carries five arithmetic condition flags: carry, overflow, zero, negative and extend. When an ALU result is presented with a flag-update strobe, the block recomputes these flags at the operand size that comes with it: byte, word or longword. The high byte carries three fields: a trace-enable bit, a supervisor-mode bit and a 3-bit interrupt priority mask.

Software can also write the word directly, with a separate enable for each byte. Writes to the high byte are accepted only while the held supervisor bit is 1. The low byte can be written in either mode.

The block also compares a pending interrupt level against the held mask and reports at once whether that level would be accepted. Level 7 always passes the mask. Bit positions are fixed as follows:

| Bit | Field |
|-----|-------|
| 0 | carry |
| 1 | overflow |
| 2 | zero |
| 3 | negative |
| 4 | extend |
| 8 to 10 | interrupt mask |
| 13 | supervisor |
| 15 | trace |

All other bits read as zero.

Top module: `psw_reg`

## Requirements
- R1: After reset the word reads 0x2700: supervisor bit set, trace clear, mask 111, and all flags clear.
- R2: On a flag update, zero (bit 2) is set exactly when the low 8 (size 0), 16 (size 1) or 32 (sizes 2 and 3) bits of the result are all zero.
- R3: On a flag update, negative (bit 3) takes bit 7, 15 or 31 of the result for size 0, 1 or 2/3 respectively.
- R4: On a flag update, carry (bit 0) takes the carry-out input and overflow (bit 1) takes the overflow input.
- R5: On a flag update, extend (bit 4) takes the new carry when the extend-follow input is 1, and keeps its value otherwise.
- R6: A write with byte-select bit 0 set loads bits 4:0 in either mode. Bits 7:5, 14, 12 and 11 always read zero.
- R7: A write with byte-select bit 1 set is ignored while the held supervisor bit (bit 13) is 0.
- R8: While bit 13 is 1, a high-byte write loads bit 15, bit 13 and bits 10:8 from the write data. The outputs for supervisor mode, trace and mask follow those bits.
- R9: When a low-byte write and a flag update fall in the same cycle, the write data wins.
- R10: An interrupt level of 7 is reported as accepted whatever the mask holds.
- R11: Levels 1 to 6 are accepted only when strictly greater than the mask, and level 0 is never accepted.
- R12: With neither a flag update nor a write, the word keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flag_upd | input | 1 | Recompute the flags from the ALU inputs |
| op_size | input | 2 | Operand size: 0 byte, 1 word, 2 or 3 longword |
| alu_res | input | 32 | ALU result |
| alu_carry | input | 1 | Carry out of the result's most significant bit |
| alu_ovf | input | 1 | Two's-complement overflow |
| x_follow | input | 1 | 1: extend copies carry; 0: extend kept |
| wr_en | input | 1 | Direct write strobe |
| wr_byte_sel | input | 2 | Bit 0 selects the low byte, bit 1 the high byte |
| wr_data | input | 16 | Write data |
| irq_lvl | input | 3 | Pending interrupt level, 0 means none |
| psw | output | 16 | Current status word |
| sup_mode | output | 1 | Supervisor bit |
| trace_en | output | 1 | Trace bit |
| irq_mask | output | 3 | Interrupt priority mask |
| irq_take | output | 1 | Pending level passes the mask |

## Verification
The hardest case to reach is the write protection. Protection depends on the held supervisor bit, and reset leaves the block in supervisor mode. To reach user mode, the stimulus first uses a permitted high-byte write that clears the supervisor bit. It then issues a second high-byte write that must be dropped, followed by a low-byte write that must still land. Before that, the stimulus sweeps the mask through several values by way of supervisor writes, so that the strictly-greater comparison is probed on both sides of its boundary.

// File: rtl/psw_pkg.sv
package psw_pkg;

  localparam int PSW_W = 16;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_LALT = 2'd3
  } op_size_e;

  localparam int B_CARRY = 0;
  localparam int B_OVF   = 1;
  localparam int B_ZERO  = 2;
  localparam int B_NEG   = 3;
  localparam int B_EXT   = 4;
  localparam int B_MLO   = 8;
  localparam int B_MHI   = 10;
  localparam int B_SUP   = 13;
  localparam int B_TRC   = 15;

  localparam int FLAG_W  = B_EXT + 1;
  localparam int MASK_W  = B_MHI - B_MLO + 1;

  localparam logic [PSW_W-1:0] IMPL_BITS = 16'hA71F;
  localparam logic [PSW_W-1:0] RESET_VAL = 16'h2700;

endpackage

// File: rtl/psw_flag_eval.sv
module psw_flag_eval
  import psw_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [1:0]        size,
  input  logic [DW-1:0]     res,
  input  logic              carry,
  input  logic              ovf,
  input  logic              x_follow,
  input  logic              x_cur,
  output logic [FLAG_W-1:0] flags
);
  localparam int BW = DW / 4;
  localparam int WW = DW / 2;

  logic zero_b, zero_w, zero_l;
  logic neg, zero;

  assign zero_b = (res[BW-1:0] == '0);
  assign zero_w = (res[WW-1:0] == '0);
  assign zero_l = (res == '0);

  always_comb begin
    unique case (op_size_e'(size))
      SZ_BYTE: begin
        neg  = res[BW-1];
        zero = zero_b;
      end
      SZ_WORD: begin
        neg  = res[WW-1];
        zero = zero_w;
      end
      default: begin
        neg  = res[DW-1];
        zero = zero_l;
      end
    endcase
  end

  always_comb begin
    flags          = '0;
    flags[B_CARRY] = carry;
    flags[B_OVF]   = ovf;
    flags[B_ZERO]  = zero;
    flags[B_NEG]   = neg;
    flags[B_EXT]   = x_follow ? carry : x_cur;
  end
endmodule

// File: rtl/psw_wr_merge.sv
module psw_wr_merge
  import psw_pkg::*;
(
  input  logic [PSW_W-1:0]  cur,
  input  logic              flag_upd,
  input  logic [FLAG_W-1:0] flags,
  input  logic              wr_en,
  input  logic [1:0]        wr_byte_sel,
  input  logic [PSW_W-1:0]  wr_data,
  output logic [PSW_W-1:0]  nxt,
  output logic              load
);
  logic lo_wr, hi_wr;

  assign lo_wr = wr_en && wr_byte_sel[0];
  assign hi_wr = wr_en && wr_byte_sel[1] && cur[B_SUP];
  assign load  = flag_upd || lo_wr || hi_wr;

  always_comb begin
    nxt = cur;
    if (flag_upd) nxt[FLAG_W-1:0] = flags;
    if (lo_wr)    nxt[FLAG_W-1:0] = wr_data[FLAG_W-1:0];
    if (hi_wr) begin
      nxt[B_TRC]         = wr_data[B_TRC];
      nxt[B_SUP]         = wr_data[B_SUP];
      nxt[B_MHI:B_MLO]   = wr_data[B_MHI:B_MLO];
    end
    nxt = nxt & IMPL_BITS;
  end
endmodule

// File: rtl/psw_irq_gate.sv
module psw_irq_gate #(
  parameter int LW = 3
) (
  input  logic [LW-1:0] mask,
  input  logic [LW-1:0] lvl,
  output logic          take
);
  localparam logic [LW-1:0] TOP = {LW{1'b1}};

  logic is_top, above;

  assign is_top = (lvl == TOP);
  assign above  = (lvl != '0) && (lvl > mask);
  assign take   = is_top || above;
endmodule

// File: rtl/psw_reg.sv
module psw_reg
  import psw_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flag_upd,
  input  logic [1:0]    op_size,
  input  logic [DW-1:0] alu_res,
  input  logic          alu_carry,
  input  logic          alu_ovf,
  input  logic          x_follow,
  input  logic          wr_en,
  input  logic [1:0]    wr_byte_sel,
  input  logic [15:0]   wr_data,
  input  logic [2:0]    irq_lvl,
  output logic [15:0]   psw,
  output logic          sup_mode,
  output logic          trace_en,
  output logic [2:0]    irq_mask,
  output logic          irq_take
);
  logic [1:0]        rst_sync;
  logic              rst_n_i;
  logic [PSW_W-1:0]  psw_q, psw_d;
  logic [FLAG_W-1:0] flags;
  logic              load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_i = rst_sync[1];

  psw_flag_eval #(.DW(DW)) u_flags (
    .size     (op_size),
    .res      (alu_res),
    .carry    (alu_carry),
    .ovf      (alu_ovf),
    .x_follow (x_follow),
    .x_cur    (psw_q[B_EXT]),
    .flags    (flags)
  );

  psw_wr_merge u_merge (
    .cur         (psw_q),
    .flag_upd    (flag_upd),
    .flags       (flags),
    .wr_en       (wr_en),
    .wr_byte_sel (wr_byte_sel),
    .wr_data     (wr_data),
    .nxt         (psw_d),
    .load        (load)
  );

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i)  psw_q <= RESET_VAL;
    else if (load) psw_q <= psw_d;
  end

  psw_irq_gate #(.LW(MASK_W)) u_irq (
    .mask (psw_q[B_MHI:B_MLO]),
    .lvl  (irq_lvl),
    .take (irq_take)
  );

  assign psw      = psw_q;
  assign sup_mode = psw_q[B_SUP];
  assign trace_en = psw_q[B_TRC];
  assign irq_mask = psw_q[B_MHI:B_MLO];

  p_rsvd_zero_r6: assert property (@(posedge clk) disable iff (!rst_n_i)
    (psw_q & ~IMPL_BITS) == '0);

  p_upper_guard_r7: assert property (@(posedge clk) disable iff (!rst_n_i)
    !(wr_en && wr_byte_sel[1] && psw_q[B_SUP]) |=> $stable(psw_q[15:8]));

  p_cv_load_r4: assert property (@(posedge clk) disable iff (!rst_n_i)
    (flag_upd && !(wr_en && wr_byte_sel[0])) |=>
      (psw_q[B_CARRY] == $past(alu_carry)) && (psw_q[B_OVF] == $past(alu_ovf)));

  p_ext_keep_r5: assert property (@(posedge clk) disable iff (!rst_n_i)
    (flag_upd && !x_follow && !(wr_en && wr_byte_sel[0])) |=> $stable(psw_q[B_EXT]));

  p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n_i)
    (!flag_upd && !wr_en) |=> $stable(psw_q));

  p_lvl7_r10: assert property (@(posedge clk) disable iff (!rst_n_i)
    (irq_lvl == 3'd7) |-> irq_take);

  p_lvl0_r11: assert property (@(posedge clk) disable iff (!rst_n_i)
    (irq_lvl == 3'd0) |-> !irq_take);

endmodule

// File: tb/psw_reg_test.sv
module psw_reg_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        flag_upd, alu_carry, alu_ovf, x_follow, wr_en, irq_take;
  logic [1:0]  op_size, wr_byte_sel;
  logic [31:0] alu_res;
  logic [15:0] wr_data, psw;
  logic [2:0]  irq_lvl, irq_mask;
  logic        sup_mode, trace_en;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  psw_reg uut (
    .clk(clk), .rst_n(rst_n), .flag_upd(flag_upd), .op_size(op_size),
    .alu_res(alu_res), .alu_carry(alu_carry), .alu_ovf(alu_ovf),
    .x_follow(x_follow), .wr_en(wr_en), .wr_byte_sel(wr_byte_sel),
    .wr_data(wr_data), .irq_lvl(irq_lvl), .psw(psw), .sup_mode(sup_mode),
    .trace_en(trace_en), .irq_mask(irq_mask), .irq_take(irq_take)
  );

  // {size[1:0], result[31:0], carry, ovf, x_follow, expected {X,N,Z,V,C}}
  localparam logic [41:0] VEC [8] = '{
    {2'd0, 32'h0000_0100, 1'b0, 1'b0, 1'b1, 5'b00100},
    {2'd0, 32'h0000_0080, 1'b1, 1'b0, 1'b1, 5'b11001},
    {2'd1, 32'h0001_0000, 1'b0, 1'b1, 1'b0, 5'b10110},
    {2'd1, 32'h0000_8000, 1'b0, 1'b0, 1'b1, 5'b01000},
    {2'd2, 32'h8000_0000, 1'b1, 1'b1, 1'b0, 5'b01011},
    {2'd2, 32'h0000_0000, 1'b1, 1'b0, 1'b1, 5'b10101},
    {2'd3, 32'h0000_8000, 1'b0, 1'b0, 1'b0, 5'b10000},
    {2'd0, 32'hFFFF_FF00, 1'b0, 1'b1, 1'b0, 5'b10110}
  };

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    flag_upd = 0; wr_en = 0; wr_byte_sel = 0; wr_data = 0;
    op_size = 0; alu_res = 0; alu_carry = 0; alu_ovf = 0; x_follow = 0;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    idle();
    wr_en = 1; wr_byte_sel = sel; wr_data = d;
    @(negedge clk);
    idle();
  endtask

  task automatic irq_chk(input logic [2:0] lvl, input logic exp, input string tag);
    irq_lvl = lvl;
    #1;
    chk({15'd0, irq_take}, {15'd0, exp}, tag);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    idle();
    irq_lvl = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(psw, 16'h2700, "R1 reset word");
    chk({13'd0, irq_mask}, 16'd7, "R1 reset mask");
    chk({15'd0, sup_mode}, 16'd1, "R1 reset supervisor");

    // R2 R3 R4 R5 flag table
    foreach (VEC[i]) begin
      @(negedge clk);
      flag_upd = 1;
      op_size = VEC[i][41:40]; alu_res = VEC[i][39:8];
      alu_carry = VEC[i][7]; alu_ovf = VEC[i][6]; x_follow = VEC[i][5];
      @(negedge clk);
      idle();
      chk(psw, {8'h27, 3'b000, VEC[i][4:0]}, $sformatf("R2 R3 R4 R5 vector %0d", i));
    end

    // R12 no strobe: word held
    @(negedge clk);
    alu_res = 32'h8000_0001; alu_carry = 1; x_follow = 1;
    @(negedge clk);
    idle();
    chk(psw, 16'h2716, "R12 hold without strobe");

    // R9 + R6: low-byte write beats flag update; bits 7:5 read zero
    @(negedge clk);
    flag_upd = 1; alu_res = 0; x_follow = 1;
    wr_en = 1; wr_byte_sel = 2'b01; wr_data = 16'h00EA;
    @(negedge clk);
    idle();
    chk(psw, 16'h270A, "R9 write over update, R6 reserved zero");

    // R8 supervisor high write
    wr(2'b10, 16'hFFFF);
    chk(psw, 16'hA70A, "R8 high write all ones");
    chk({14'd0, trace_en, sup_mode}, 16'd3, "R8 trace and supervisor outputs");

    // R10 R11 with mask 7
    irq_chk(3'd6, 1'b0, "R11 level 6 under mask 7");
    irq_chk(3'd7, 1'b1, "R10 level 7 under mask 7");

    wr(2'b10, 16'h2300);
    chk({13'd0, irq_mask}, 16'd3, "R8 mask 3");
    irq_chk(3'd3, 1'b0, "R11 level equal to mask");
    irq_chk(3'd4, 1'b1, "R11 level above mask");
    irq_chk(3'd0, 1'b0, "R11 level 0");

    wr(2'b10, 16'h2000);
    irq_chk(3'd1, 1'b1, "R11 level 1 mask 0");
    irq_chk(3'd0, 1'b0, "R11 level 0 mask 0");
    irq_lvl = 0;

    // R7 leave supervisor, then high write ignored, low still writable
    wr(2'b10, 16'h0700);
    chk(psw, 16'h070A, "R8 clear supervisor");
    wr(2'b11, 16'hA515);
    chk(psw, 16'h0715, "R7 high ignored, R6 low written in user");
    chk({15'd0, sup_mode}, 16'd0, "R7 still user");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule